// File: doc/BRIEF.md
# DMA Channel Command and Status Controller

This block is the control plane of one memory-to-memory DMA channel. Software programs a beat count and an interrupt mask through a small 32-bit register port. It then steers the channel with one-hot command bits: start, pause, continue after a pause, abort, force to idle, and wipe back to defaults. The block keeps the channel state and exposes it as live flags in a status word. The same word also carries two sticky interrupt flags that software clears by writing ones. A level interrupt output follows those flags through the mask.

The transfer engine is attached through two valid/ready channels. On the beat channel the engine offers one completed data beat per handshake. On the error channel it offers one fault together with a two-bit cause code. Both ready signals are high only while the channel is running and no command write is happening in the same cycle. The engine must therefore hold `beat_valid` or `err_valid`, with the cause stable, until ready rises. While the channel is paused or idle, the engine is back-pressured indefinitely, so the remaining count stays frozen and software reads a stable residue. If a beat and an error are both accepted in one cycle, the error takes effect and the beat is not counted.

The register port has no wait states: writes take effect at the clock edge, and `reg_rdata` shows the register selected by `reg_addr` combinationally. Offsets are CMD 0x00, STATUS 0x04, IRQ_MASK 0x08, FAULT 0x0C and COUNT 0x10. Any other offset reads zero.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset the channel is idle. STATUS reads 0x0004_0000, with the idle flag at bit 18 and nothing else set. COUNT, IRQ_MASK and FAULT read 0, and `beat_ready`, `err_ready` and `irq` are low.
- R2: Writing CMD bit 0 (start) while the channel is not running or paused, with a non-zero COUNT, puts it in the running state. In that state no live flag (bits 16 to 21) is set and `beat_ready` is high. Each accepted beat decrements COUNT by one.
- R3: The beat that brings COUNT to zero moves the channel to the finished state on the next edge. That sets STATUS bit 16 and the sticky done flag at bit 0, and drops `beat_ready`.
- R4: A start command with COUNT at zero goes straight to the finished state and sets the sticky done flag.
- R5: The pause command (CMD bit 4) takes effect only while running, and the resume command (CMD bit 5) only while paused; otherwise each is ignored. While paused, STATUS bit 20 is set, both ready outputs are low and COUNT does not change.
- R6: STATUS bit 21 reads 1 exactly when the channel is paused and the engine is holding `beat_valid` high.
- R7: The abort command (CMD bit 3) from running or paused stops the channel. STATUS bit 19 is set, the done flags stay unchanged and COUNT keeps the residue. In any other state the command is ignored.
- R8: An accepted error moves the channel to the faulted state, setting STATUS bit 17 and the sticky error flag at bit 1. Cause code 0 (read response), 1 (write response) and 2 (read poison) set FAULT bit 16, 17 or 18 respectively, and code 3 sets no FAULT bit. A beat accepted in the same cycle is not counted. A start command clears FAULT.
- R9: Writing STATUS clears each sticky flag (bit 0 done, bit 1 error) whose written bit is 1. A flag being set by an event in the same cycle stays set.
- R10: `irq` is high exactly when (done flag AND IRQ_MASK bit 0) OR (error flag AND IRQ_MASK bit 1).
- R11: The wipe command (CMD bit 1) returns the channel to idle and zeroes COUNT, IRQ_MASK, FAULT and both sticky flags.
- R12: The idle command (CMD bit 2) returns the channel from any state to idle (STATUS bit 18) without setting any sticky flag, and COUNT keeps its value.
- R13: When several CMD bits are written together, only the highest-priority one is acted on: wipe, then idle, then abort, then pause, then resume, then start. The others are dropped even when the chosen command has no effect in the current state.
- R14: Writes to COUNT are ignored while running or paused. In any cycle with a CMD write, both ready outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (5) | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| beat_valid | input | 1 | Engine offers a completed beat |
| beat_ready | output | 1 | Beat accepted when high with `beat_valid` |
| err_valid | input | 1 | Engine offers a fault |
| err_code | input | 2 | Fault cause code, held with `err_valid` |
| err_ready | output | 1 | Fault accepted when high with `err_valid` |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the cycles where two things meet.

- **Error and beat together.** An error and a beat arrive in the same cycle. A design that counted the beat anyway would show a residue one lower than expected.
- **Clear write and event together.** A status clear-write lands on the cycle the final beat sets the done flag. A design that let the clear win would lose the interrupt.
- **Combined command bits.** A design that applied several bits of one command write, or picked the wrong priority, ends up in the wrong state.
- **Engine during a pause or command write.** Beats are offered while paused and during a command write. A design that still raised ready would let the count drift behind software's back.
- **Ignored commands.** Pause, resume, abort and count writes are sent in states where they must do nothing, to catch designs that act on them anyway.

// File: rtl/dma_chan_ctl_pkg.sv
package dma_chan_ctl_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_PAUSE, ST_STOP, ST_DONE, ST_ERR
  } chan_state_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_WIPE, OP_IDLE, OP_ABORT, OP_PAUSE, OP_RESUME, OP_START
  } chan_op_e;

  // command bit positions
  localparam int CMD_BITS  = 6;
  localparam int CB_START  = 0;
  localparam int CB_WIPE   = 1;
  localparam int CB_IDLE   = 2;
  localparam int CB_ABORT  = 3;
  localparam int CB_PAUSE  = 4;
  localparam int CB_RESUME = 5;

  // status bit positions
  localparam int SB_DONE_F = 0;
  localparam int SB_ERR_F  = 1;
  localparam int SB_FIN    = 16;
  localparam int SB_FAULT  = 17;
  localparam int SB_IDLE   = 18;
  localparam int SB_STOP   = 19;
  localparam int SB_PAUSE  = 20;
  localparam int SB_WAIT   = 21;

  localparam int MASK_W     = 2;
  localparam int NUM_CAUSE  = 3;
  localparam int ERR_CODE_W = 2;
  localparam int FAULT_LSB  = 16;

  // register byte offsets
  localparam int OFS_CMD   = 'h00;
  localparam int OFS_STAT  = 'h04;
  localparam int OFS_MASK  = 'h08;
  localparam int OFS_FAULT = 'h0C;
  localparam int OFS_COUNT = 'h10;
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_chan_ctl_pkg::*;
(
  input  logic                wr,
  input  logic [CMD_BITS-1:0] bits,
  output chan_op_e            op
);
  timeunit 1ns;
  timeprecision 100ps;

  always_comb begin
    op = OP_NONE;
    if (wr) begin
      if      (bits[CB_WIPE])   op = OP_WIPE;
      else if (bits[CB_IDLE])   op = OP_IDLE;
      else if (bits[CB_ABORT])  op = OP_ABORT;
      else if (bits[CB_PAUSE])  op = OP_PAUSE;
      else if (bits[CB_RESUME]) op = OP_RESUME;
      else if (bits[CB_START])  op = OP_START;
    end
  end
endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_chan_ctl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chan_op_e         op,
  input  logic             hold,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             beat_valid,
  output logic             beat_ready,
  input  logic             err_valid,
  output logic             err_ready,
  output chan_state_e      state,
  output logic [CNT_W-1:0] remaining,
  output logic             done_evt,
  output logic             err_evt,
  output logic             start_evt
);
  timeunit 1ns;
  timeprecision 100ps;

  chan_state_e      st_n;
  logic [CNT_W-1:0] cnt_n;
  logic             active, err_acc, beat_acc, last_beat;

  assign active     = (state == ST_RUN) || (state == ST_PAUSE);
  assign beat_ready = (state == ST_RUN) && !hold;
  assign err_ready  = (state == ST_RUN) && !hold;
  assign err_acc    = err_valid && err_ready;
  assign beat_acc   = beat_valid && beat_ready && !err_acc;
  assign last_beat  = (remaining == CNT_W'(1));

  always_comb begin
    st_n      = state;
    cnt_n     = remaining;
    done_evt  = 1'b0;
    err_evt   = 1'b0;
    start_evt = 1'b0;
    case (op)
      OP_WIPE: begin
        st_n  = ST_IDLE;
        cnt_n = '0;
      end
      OP_IDLE:   st_n = ST_IDLE;
      OP_ABORT:  if (active) st_n = ST_STOP;
      OP_PAUSE:  if (state == ST_RUN) st_n = ST_PAUSE;
      OP_RESUME: if (state == ST_PAUSE) st_n = ST_RUN;
      OP_START: begin
        if (!active) begin
          start_evt = 1'b1;
          if (remaining == '0) begin
            st_n     = ST_DONE;
            done_evt = 1'b1;
          end else begin
            st_n = ST_RUN;
          end
        end
      end
      default: begin
        if (err_acc) begin
          st_n    = ST_ERR;
          err_evt = 1'b1;
        end else if (beat_acc) begin
          cnt_n = remaining - CNT_W'(1);
          if (last_beat) begin
            st_n     = ST_DONE;
            done_evt = 1'b1;
          end
        end
        if (cnt_wr && !active) cnt_n = cnt_wdata;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      remaining <= '0;
    end else begin
      state     <= st_n;
      remaining <= cnt_n;
    end
  end
endmodule

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl
  import dma_chan_ctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wipe,
  input  logic                  start,
  input  logic                  done_evt,
  input  logic                  err_evt,
  input  logic [ERR_CODE_W-1:0] err_code,
  input  logic                  stat_wr,
  input  logic [1:0]            stat_clr,
  input  logic                  mask_wr,
  input  logic [MASK_W-1:0]     mask_wdata,
  output logic                  intr_done,
  output logic                  intr_err,
  output logic [MASK_W-1:0]     mask,
  output logic [NUM_CAUSE-1:0]  cause,
  output logic                  irq
);
  timeunit 1ns;
  timeprecision 100ps;

  logic clr_done, clr_err;
  assign clr_done = stat_wr && stat_clr[SB_DONE_F];
  assign clr_err  = stat_wr && stat_clr[SB_ERR_F];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intr_done <= 1'b0;
      intr_err  <= 1'b0;
      mask      <= '0;
    end else if (wipe) begin
      intr_done <= 1'b0;
      intr_err  <= 1'b0;
      mask      <= '0;
    end else begin
      intr_done <= (intr_done && !clr_done) || done_evt;
      intr_err  <= (intr_err && !clr_err) || err_evt;
      if (mask_wr) mask <= mask_wdata;
    end
  end

  for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_cause
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cause[i] <= 1'b0;
      else if (wipe || start)   cause[i] <= 1'b0;
      else if (err_evt && err_code == ERR_CODE_W'(i)) cause[i] <= 1'b1;
    end
  end

  assign irq = (intr_done && mask[0]) || (intr_err && mask[1]);
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_ctl_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wen,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  beat_valid,
  output logic                  beat_ready,
  input  logic                  err_valid,
  input  logic [ERR_CODE_W-1:0] err_code,
  output logic                  err_ready,
  output logic                  irq
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_FAULT = ADDR_W'(OFS_FAULT);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);

  logic wr_cmd, wr_stat, wr_mask, wr_count;
  assign wr_cmd   = reg_wen && (reg_addr == A_CMD);
  assign wr_stat  = reg_wen && (reg_addr == A_STAT);
  assign wr_mask  = reg_wen && (reg_addr == A_MASK);
  assign wr_count = reg_wen && (reg_addr == A_COUNT);

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^reg_wdata[31:CNT_W];

  chan_op_e             op;
  chan_state_e          state;
  logic [CNT_W-1:0]     remaining;
  logic                 done_evt, err_evt, start_evt;
  logic                 intr_done, intr_err;
  logic [MASK_W-1:0]    mask;
  logic [NUM_CAUSE-1:0] cause;

  dma_cmd_decode u_dec (
    .wr   (wr_cmd),
    .bits (reg_wdata[CMD_BITS-1:0]),
    .op   (op)
  );

  dma_chan_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .hold       (wr_cmd),
    .cnt_wr     (wr_count),
    .cnt_wdata  (reg_wdata[CNT_W-1:0]),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .err_valid  (err_valid),
    .err_ready  (err_ready),
    .state      (state),
    .remaining  (remaining),
    .done_evt   (done_evt),
    .err_evt    (err_evt),
    .start_evt  (start_evt)
  );

  dma_irq_ctl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wipe       (op == OP_WIPE),
    .start      (start_evt),
    .done_evt   (done_evt),
    .err_evt    (err_evt),
    .err_code   (err_code),
    .stat_wr    (wr_stat),
    .stat_clr   (reg_wdata[1:0]),
    .mask_wr    (wr_mask),
    .mask_wdata (reg_wdata[MASK_W-1:0]),
    .intr_done  (intr_done),
    .intr_err   (intr_err),
    .mask       (mask),
    .cause      (cause),
    .irq        (irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT: begin
        reg_rdata[SB_DONE_F] = intr_done;
        reg_rdata[SB_ERR_F]  = intr_err;
        reg_rdata[SB_FIN]    = (state == ST_DONE);
        reg_rdata[SB_FAULT]  = (state == ST_ERR);
        reg_rdata[SB_IDLE]   = (state == ST_IDLE);
        reg_rdata[SB_STOP]   = (state == ST_STOP);
        reg_rdata[SB_PAUSE]  = (state == ST_PAUSE);
        reg_rdata[SB_WAIT]   = (state == ST_PAUSE) && beat_valid;
      end
      A_MASK:  reg_rdata[MASK_W-1:0] = mask;
      A_FAULT: reg_rdata[FAULT_LSB +: NUM_CAUSE] = cause;
      A_COUNT: reg_rdata[CNT_W-1:0] = remaining;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk
  import dma_chan_ctl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input chan_state_e           state,
  input chan_op_e              op,
  input logic [CNT_W-1:0]      remaining,
  input logic                  beat_valid,
  input logic                  beat_ready,
  input logic                  err_valid,
  input logic                  err_ready,
  input logic [ERR_CODE_W-1:0] err_code,
  input logic                  intr_done,
  input logic                  intr_err,
  input logic [MASK_W-1:0]     mask,
  input logic [NUM_CAUSE-1:0]  cause,
  input logic                  irq
);
  timeunit 1ns;
  timeprecision 100ps;

  assert_ready_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ready |-> state == ST_RUN);

  assert_last_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && !err_valid && remaining == CNT_W'(1))
      |=> (state == ST_DONE && intr_done));

  assert_pause_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAUSE) |-> (!beat_ready && !err_ready));

  assert_pause_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAUSE && op == OP_NONE) |=> remaining == $past(remaining));

  assert_abort_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ABORT && (state == ST_RUN || state == ST_PAUSE))
      |=> (state == ST_STOP && intr_done == $past(intr_done)));

  assert_fault_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_ready && int'(err_code) < NUM_CAUSE)
      |=> (state == ST_ERR && intr_err && cause != '0));

  assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  assert_wipe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WIPE) |=> (state == ST_IDLE && mask == '0 && remaining == '0
                         && !intr_done && !intr_err && cause == '0));
endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state      (state),
  .op         (op),
  .remaining  (remaining),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .err_valid  (err_valid),
  .err_ready  (err_ready),
  .err_code   (err_code),
  .intr_done  (intr_done),
  .intr_err   (intr_err),
  .mask       (mask),
  .cause      (cause),
  .irq        (irq)
);

// File: tb/dma_chan_ctl_test.sv
module dma_chan_ctl_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [4:0] A_CMD = 5'h00, A_STAT = 5'h04, A_MASK = 5'h08,
                         A_FAULT = 5'h0C, A_COUNT = 5'h10;
  localparam int S_IDLE = 0, S_RUN = 1, S_PAUSE = 2, S_STOP = 3, S_DONE = 4, S_ERR = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [4:0]  reg_addr = A_STAT;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        beat_valid = 1'b0, err_valid = 1'b0;
  logic [1:0]  err_code = '0;
  logic        beat_ready, err_ready, irq;

  int    checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_chan_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .err_valid(err_valid), .err_code(err_code),
    .err_ready(err_ready), .irq(irq)
  );

  // behavioural reference model
  int          m_st;
  logic [15:0] m_cnt;
  logic [1:0]  m_mask;
  logic [2:0]  m_fault;
  bit          m_done_f, m_err_f;

  function automatic bit exp_ready();
    return m_st == S_RUN && !(reg_wen && reg_addr == A_CMD);
  endfunction

  function automatic logic [31:0] exp_read(logic [4:0] a);
    logic [31:0] v = '0;
    case (a)
      A_STAT: begin
        v[0] = m_done_f; v[1] = m_err_f;
        v[16] = m_st == S_DONE; v[17] = m_st == S_ERR; v[18] = m_st == S_IDLE;
        v[19] = m_st == S_STOP; v[20] = m_st == S_PAUSE;
        v[21] = m_st == S_PAUSE && beat_valid;
      end
      A_MASK:  v[1:0] = m_mask;
      A_FAULT: v[18:16] = m_fault;
      A_COUNT: v[15:0] = m_cnt;
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    bit act, sd, se;
    int nst;
    logic [15:0] nc;
    if (!rst_n) begin
      m_st = S_IDLE; m_cnt = '0; m_mask = '0; m_fault = '0;
      m_done_f = 0; m_err_f = 0;
    end else begin
      act = m_st == S_RUN || m_st == S_PAUSE;
      nst = m_st; nc = m_cnt; sd = 0; se = 0;
      if (reg_wen && reg_addr == A_CMD) begin
        if (reg_wdata[1]) begin
          nst = S_IDLE; nc = '0; m_mask = '0; m_fault = '0; m_done_f = 0; m_err_f = 0;
        end else if (reg_wdata[2]) nst = S_IDLE;
        else if (reg_wdata[3]) begin if (act) nst = S_STOP; end
        else if (reg_wdata[4]) begin if (m_st == S_RUN) nst = S_PAUSE; end
        else if (reg_wdata[5]) begin if (m_st == S_PAUSE) nst = S_RUN; end
        else if (reg_wdata[0] && !act) begin
          m_fault = '0;
          if (m_cnt == 0) begin nst = S_DONE; sd = 1; end
          else nst = S_RUN;
        end
      end else if (m_st == S_RUN) begin
        if (err_valid) begin
          nst = S_ERR; se = 1;
          if (err_code != 2'd3) m_fault[err_code] = 1'b1;
        end else if (beat_valid) begin
          nc = m_cnt - 16'd1;
          if (nc == 0) begin nst = S_DONE; sd = 1; end
        end
      end
      if (reg_wen && reg_addr == A_STAT) begin
        if (reg_wdata[0]) m_done_f = 0;
        if (reg_wdata[1]) m_err_f = 0;
      end
      if (sd) m_done_f = 1;
      if (se) m_err_f = 1;
      if (reg_wen && reg_addr == A_MASK) m_mask = reg_wdata[1:0];
      if (reg_wen && reg_addr == A_COUNT && !act) nc = reg_wdata[15:0];
      m_st = nst; m_cnt = nc;
    end
  end

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, got, exp);
    end
  endtask

  task automatic cyc(bit wen, logic [4:0] a, logic [31:0] d, bit bv, bit ev, logic [1:0] ec);
    @(negedge clk);
    reg_wen = wen; reg_addr = a; reg_wdata = d;
    beat_valid = bv; err_valid = ev; err_code = ec;
    #1;
    chk("rdata", reg_rdata, exp_read(a));
    chk("beat_ready", 32'(beat_ready), 32'(exp_ready()));
    chk("err_ready", 32'(err_ready), 32'(exp_ready()));
    chk("irq", 32'(irq), 32'((m_done_f && m_mask[0]) || (m_err_f && m_mask[1])));
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d); cyc(1, a, d, 0, 0, 0); endtask
  task automatic rd(logic [4:0] a); cyc(0, a, 0, 0, 0, 0); endtask
  task automatic beats(int n);
    for (int i = 0; i < n; i++) cyc(0, A_STAT, 0, 1, 0, 0);
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) rd(A_STAT);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected <= 50000 cycles", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; idle(2); rd(A_COUNT); rd(A_MASK); rd(A_FAULT); rd(5'h14);

    cur_req = "R10"; wr(A_MASK, 3); rd(A_MASK);
    cur_req = "R2"; wr(A_COUNT, 4); wr(A_CMD, 1); beats(2); rd(A_COUNT);
    cur_req = "R14"; cyc(1, A_CMD, 0, 1, 0, 0); rd(A_COUNT);
    wr(A_COUNT, 9); rd(A_COUNT);
    cur_req = "R3"; beats(2); idle(2); rd(A_COUNT);
    cur_req = "R9"; wr(A_STAT, 1); idle(1);

    cur_req = "R4"; wr(A_COUNT, 0); wr(A_CMD, 1); idle(1); wr(A_STAT, 3);

    cur_req = "R5"; wr(A_COUNT, 6); wr(A_CMD, 32'h10); idle(1);
    wr(A_CMD, 1); beats(2); wr(A_CMD, 32'h10);
    cur_req = "R6"; beats(3); rd(A_COUNT);
    cur_req = "R14"; wr(A_COUNT, 1); rd(A_COUNT);
    cur_req = "R5"; wr(A_CMD, 32'h20); beats(4); wr(A_CMD, 32'h20); idle(1); wr(A_STAT, 3);

    cur_req = "R7"; wr(A_COUNT, 5); wr(A_CMD, 1); beats(2); wr(A_CMD, 8);
    beats(2); rd(A_COUNT); wr(A_CMD, 8); idle(1);

    cur_req = "R8";
    for (int c = 0; c < 4; c++) begin
      wr(A_COUNT, 3); wr(A_CMD, 1); beats(1);
      cyc(0, A_STAT, 0, 1, 1, 2'(c));
      rd(A_FAULT); rd(A_COUNT); wr(A_STAT, 2);
    end

    cur_req = "R9"; wr(A_COUNT, 1); wr(A_CMD, 1); cyc(1, A_STAT, 3, 1, 0, 0);
    idle(1); wr(A_STAT, 1);

    cur_req = "R12"; wr(A_COUNT, 4); wr(A_CMD, 1); beats(1); wr(A_CMD, 4);
    idle(1); rd(A_COUNT);

    cur_req = "R13"; wr(A_COUNT, 5); wr(A_CMD, 1); wr(A_CMD, 32'h18); idle(1);
    wr(A_CMD, 1); wr(A_CMD, 32'h30); idle(1); wr(A_CMD, 32'h21); beats(1);
    wr(A_CMD, 32'h11); idle(1); wr(A_CMD, 32'h3F); rd(A_MASK); rd(A_COUNT);

    cur_req = "R11"; wr(A_MASK, 3); wr(A_COUNT, 7); wr(A_CMD, 1);
    cyc(0, A_STAT, 0, 0, 1, 2'd1); rd(A_FAULT); wr(A_CMD, 2);
    rd(A_MASK); rd(A_COUNT); rd(A_FAULT); idle(2);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule